// File: doc/BRIEF.md
# Accumulator ALU with nibble-split flag generation

This block is the combinational arithmetic and logic stage of a small accumulator-style processor. Each cycle the decoder hands it a 3-bit operation code, a left operand (normally the accumulator), a right operand, the current carry flag and a per-instruction permission to update carry. It returns the result, a strobe saying whether that result is to be written back, and the four condition flags: zero, subtract, half-carry and carry.

The adder is split into nibble-wide stages so that the carry (or borrow) out of the lowest nibble is available as the half-carry flag. Compare reuses the subtract path and only differs in that it never asks for writeback. The add-with-carry and subtract-with-carry forms fold the incoming carry into the right operand before the operation, so a right operand of all ones plus carry behaves as a full 2^WIDTH term. The nibble width, data width and the adder structure (a chain of nibble stages or one flat adder plus a separate low-nibble adder) are parameters.

Top module: `acc_alu8`

## Requirements
- R1: The operation code is 3 bits: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 AND, 5 XOR, 6 OR, 7 compare. For add, the result is (lhs + rhs) mod 256, carry is bit 8 of the 9-bit sum and half-carry is bit 4 of the sum of the low nibbles.
- R2: For add-with-carry and subtract-with-carry, when carry_i is 1 the right operand is first increased by one as a 9-bit value (so 0xFF becomes 0x100, whose low nibble is 0); carry_i has no effect on any other operation.
- R3: For subtract, subtract-with-carry and compare, result_o is (lhs - rhs') mod 256, carry is 1 exactly when lhs < rhs' (borrow out of bit 7) and half-carry is 1 exactly when lhs[3:0] < rhs'[3:0] (borrow out of bit 3), rhs' being the right operand after R2.
- R4: sub_o is 1 for subtract, subtract-with-carry and compare, and 0 for the other five operations.
- R5: AND, XOR and OR give the bitwise result; half-carry is 1 for AND and 0 for XOR and OR.
- R6: zero_o is 1 exactly when result_o is 0, compare included.
- R7: result_we_o is 0 for compare and 1 for every other operation; for compare result_o still presents the difference.
- R8: When upd_carry_i is 0, carry_o equals carry_i whatever the operation and operands.
- R9: For AND, XOR and OR with upd_carry_i at 1, carry_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code (encoding in R1) |
| lhs_i | input | 8 | Left operand |
| rhs_i | input | 8 | Right operand |
| carry_i | input | 1 | Current carry flag |
| upd_carry_i | input | 1 | Allow this operation to change the carry flag |
| result_o | output | 8 | Operation result |
| result_we_o | output | 1 | Result is to be written back |
| zero_o | output | 1 | Result equals zero |
| sub_o | output | 1 | Operation was a subtraction or compare |
| half_o | output | 1 | Carry or borrow out of the low nibble |
| carry_o | output | 1 | New carry flag |

## Verification
The hardest case to reach is the right operand of 0xFF together with an incoming carry on the with-carry forms, where the effective operand spills into a ninth bit and carry must come from that spill while the low-nibble term is zero. The bench sweeps every operation against every pair of operands with both values of the incoming carry, so this corner and every nibble boundary are visited; the carry-update enable is derived from operand bits so that both held and updated carry appear for every operation throughout the sweep.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_ADC = 3'd1,
      ALU_SUB = 3'd2,
      ALU_SBC = 3'd3,
      ALU_AND = 3'd4,
      ALU_XOR = 3'd5,
      ALU_OR  = 3'd6,
      ALU_CMP = 3'd7
   } alu_op_e;

   localparam int ADDER_CHAIN = 0;
   localparam int ADDER_FLAT  = 1;

   function automatic logic op_is_sub(input logic [2:0] op);
      return (op == ALU_SUB) || (op == ALU_SBC) || (op == ALU_CMP);
   endfunction

   function automatic logic op_uses_carry(input logic [2:0] op);
      return (op == ALU_ADC) || (op == ALU_SBC);
   endfunction

   function automatic logic op_is_logic(input logic [2:0] op);
      return (op == ALU_AND) || (op == ALU_XOR) || (op == ALU_OR);
   endfunction

endpackage

// File: rtl/acc_alu_slice.sv
module acc_alu_slice #(
   parameter int NIB = 4
) (
   input  logic [NIB-1:0] a_i,
   input  logic [NIB-1:0] b_i,
   input  logic           c_i,
   output logic [NIB-1:0] s_o,
   output logic           c_o
);
   logic [NIB:0] wide;

   always_comb begin
      wide = {1'b0, a_i} + {1'b0, b_i} + {{NIB{1'b0}}, c_i};
      s_o  = wide[NIB-1:0];
      c_o  = wide[NIB];
   end
endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int NIB   = 4,
   parameter int STYLE = ADDER_CHAIN
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] e_i,
   input  logic             e_top_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             half_o,
   output logic             carry_o
);
   localparam int STAGES = WIDTH / NIB;

   logic [WIDTH-1:0] bx;
   logic             low_c;
   logic             top_c;

   assign bx = sub_i ? ~e_i : e_i;

   generate
      if (STYLE == ADDER_CHAIN) begin : g_chain
         logic [STAGES:0] cc;
         assign cc[0] = sub_i;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            acc_alu_slice #(.NIB(NIB)) u_slice (
               .a_i (a_i[i*NIB +: NIB]),
               .b_i (bx[i*NIB +: NIB]),
               .c_i (cc[i]),
               .s_o (sum_o[i*NIB +: NIB]),
               .c_o (cc[i+1])
            );
         end
         assign low_c = cc[1];
         assign top_c = cc[STAGES];
      end else begin : g_flat
         logic [WIDTH:0] wide;
         logic [NIB:0]   low;
         always_comb begin
            wide = {1'b0, a_i} + {1'b0, bx} + {{WIDTH{1'b0}}, sub_i};
            low  = {1'b0, a_i[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, sub_i};
         end
         assign sum_o = wide[WIDTH-1:0];
         assign low_c = low[NIB];
         assign top_c = wide[WIDTH];
      end
   endgenerate

   // A carry-out of the complemented form means no borrow.
   assign half_o  = sub_i ? ~low_c : low_c;
   assign carry_o = (sub_i ? ~top_c : top_c) | e_top_i;
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] y_o
);
   always_comb begin
      unique case (op_i)
         ALU_AND: y_o = a_i & b_i;
         ALU_XOR: y_o = a_i ^ b_i;
         ALU_OR:  y_o = a_i | b_i;
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/acc_alu8.sv
module acc_alu8
   import acc_alu_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int NIB   = 4,
   parameter int STYLE = ADDER_CHAIN
) (
   input  logic [2:0]       op_i,
   input  logic [WIDTH-1:0] lhs_i,
   input  logic [WIDTH-1:0] rhs_i,
   input  logic             carry_i,
   input  logic             upd_carry_i,
   output logic [WIDTH-1:0] result_o,
   output logic             result_we_o,
   output logic             zero_o,
   output logic             sub_o,
   output logic             half_o,
   output logic             carry_o
);
   generate
      if (NIB < 1) begin : g_bad_nib
         $error("acc_alu8: NIB must be at least 1");
      end
      if (WIDTH <= NIB || (WIDTH % NIB) != 0) begin : g_bad_width
         $error("acc_alu8: WIDTH must be a multiple of NIB and larger than it");
      end
      if (STYLE != ADDER_CHAIN && STYLE != ADDER_FLAT) begin : g_bad_style
         $error("acc_alu8: unknown STYLE");
      end
   endgenerate

   logic             is_sub;
   logic             is_log;
   logic             inc;
   logic [WIDTH:0]   eff;
   logic [WIDTH-1:0] arith_y;
   logic [WIDTH-1:0] logic_y;
   logic             arith_h;
   logic             arith_c;
   logic             new_c;

   assign is_sub = op_is_sub(op_i);
   assign is_log = op_is_logic(op_i);
   assign inc    = op_uses_carry(op_i) & carry_i;
   assign eff    = {1'b0, rhs_i} + {{WIDTH{1'b0}}, inc};

   acc_alu_addsub #(.WIDTH(WIDTH), .NIB(NIB), .STYLE(STYLE)) u_addsub (
      .a_i     (lhs_i),
      .e_i     (eff[WIDTH-1:0]),
      .e_top_i (eff[WIDTH]),
      .sub_i   (is_sub),
      .sum_o   (arith_y),
      .half_o  (arith_h),
      .carry_o (arith_c)
   );

   acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op_i (op_i),
      .a_i  (lhs_i),
      .b_i  (rhs_i),
      .y_o  (logic_y)
   );

   always_comb begin
      result_o    = is_log ? logic_y : arith_y;
      half_o      = is_log ? (op_i == ALU_AND) : arith_h;
      new_c       = is_log ? 1'b0 : arith_c;
      carry_o     = upd_carry_i ? new_c : carry_i;
      zero_o      = (result_o == '0);
      sub_o       = is_sub;
      result_we_o = (op_i != ALU_CMP);
   end
endmodule

// File: rtl/acc_alu8_chk.sv
module acc_alu8_chk #(
   parameter int WIDTH = 8
) (
   input logic [2:0]       op_i,
   input logic [WIDTH-1:0] lhs_i,
   input logic [WIDTH-1:0] rhs_i,
   input logic             carry_i,
   input logic             upd_carry_i,
   input logic [WIDTH-1:0] result_o,
   input logic             result_we_o,
   input logic             zero_o,
   input logic             sub_o,
   input logic             half_o,
   input logic             carry_o
);
   always_comb begin
      if (!upd_carry_i) begin
         // R8
         carry_hold_chk: assert (carry_o == carry_i);
      end
      if (upd_carry_i && op_i[2] && op_i != 3'd7) begin
         // R9
         logic_carry_clear_chk: assert (carry_o == 1'b0);
      end
      // R4
      sub_flag_chk: assert (sub_o == (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd7));
      // R7
      cmp_no_write_chk: assert (result_we_o == (op_i != 3'd7));
      if (op_i == 3'd4) begin
         // R5
         and_half_chk: assert (half_o == 1'b1);
      end
      if (op_i == 3'd5 || op_i == 3'd6) begin
         // R5
         orxor_half_chk: assert (half_o == 1'b0);
      end
      if (op_i == 3'd4) begin
         // R5
         and_result_chk: assert (result_o == (lhs_i & rhs_i));
      end
      // R6
      zero_flag_chk: assert (zero_o == (result_o == '0));
   end
endmodule

bind acc_alu8 acc_alu8_chk #(.WIDTH(WIDTH)) u_chk (
   .op_i        (op_i),
   .lhs_i       (lhs_i),
   .rhs_i       (rhs_i),
   .carry_i     (carry_i),
   .upd_carry_i (upd_carry_i),
   .result_o    (result_o),
   .result_we_o (result_we_o),
   .zero_o      (zero_o),
   .sub_o       (sub_o),
   .half_o      (half_o),
   .carry_o     (carry_o)
);

// File: tb/tb_acc_alu8.sv
`timescale 1ns/100ps
module tb_acc_alu8;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_i = 3'd0;
   logic [7:0] lhs_i = 8'd0;
   logic [7:0] rhs_i = 8'd0;
   logic       carry_i = 1'b0;
   logic       upd_carry_i = 1'b0;
   logic [7:0] result_o;
   logic       result_we_o, zero_o, sub_o, half_o, carry_o;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cycles <= cycles + 1;

   acc_alu8 dut (
      .op_i(op_i), .lhs_i(lhs_i), .rhs_i(rhs_i), .carry_i(carry_i),
      .upd_carry_i(upd_carry_i), .result_o(result_o), .result_we_o(result_we_o),
      .zero_o(zero_o), .sub_o(sub_o), .half_o(half_o), .carry_o(carry_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s op=%0d lhs=%02h rhs=%02h c=%0d u=%0d actual=%0h expected=%0h",
                  req, what, op_i, lhs_i, rhs_i, carry_i, upd_carry_i, act, exp);
      end
   endtask

   task automatic run_vec(input int op, input int a, input int b, input int cin, input int upd);
      int eff, full, res, h, c, cfinal;
      bit arith_add, arith_sub;
      string rq;
      op_i = op[2:0]; lhs_i = a[7:0]; rhs_i = b[7:0];
      carry_i = cin[0]; upd_carry_i = upd[0];
      arith_add = (op == 0 || op == 1);
      arith_sub = (op == 2 || op == 3 || op == 7);
      eff = b + (((op == 1 || op == 3) && cin == 1) ? 1 : 0);
      if (arith_add) begin
         full = a + eff;
         res  = full & 255;
         h    = ((a & 15) + (eff & 15)) > 15 ? 1 : 0;
         c    = full > 255 ? 1 : 0;
         rq   = (op == 1) ? "R2" : "R1";
      end else if (arith_sub) begin
         res  = (a - eff) & 255;
         h    = (a & 15) < (eff & 15) ? 1 : 0;
         c    = a < eff ? 1 : 0;
         rq   = (op == 3) ? "R2" : "R3";
      end else begin
         res  = (op == 4) ? (a & b) : (op == 5) ? (a ^ b) : (a | b);
         h    = (op == 4) ? 1 : 0;
         c    = 0;
         rq   = "R5";
      end
      cfinal = upd ? c : cin;
      #0.1;
      chk(rq, "result", int'(result_o), res);
      chk(rq, "half", int'(half_o), h);
      if (!upd) chk("R8", "carry", int'(carry_o), cfinal);
      else if (!arith_add && !arith_sub) chk("R9", "carry", int'(carry_o), 0);
      else chk(rq, "carry", int'(carry_o), cfinal);
      chk("R4", "sub", int'(sub_o), arith_sub ? 1 : 0);
      chk("R6", "zero", int'(zero_o), res == 0 ? 1 : 0);
      chk("R7", "we", int'(result_we_o), op == 7 ? 0 : 1);
      #0.1;
   endtask

   initial begin
      #12 rst_n = 1'b1;
      // idle state: add of zeros
      #0.1;
      chk("R6", "idle zero", int'(zero_o), 1);
      chk("R7", "idle we", int'(result_we_o), 1);
      chk("R8", "idle carry", int'(carry_o), 0);
      // named corners
      run_vec(1, 8'h00, 8'hFF, 1, 1);   // R2: 0x100 spill, carry 1, half 0
      run_vec(3, 8'h00, 8'hFF, 1, 1);   // R2: borrow from spill
      run_vec(1, 8'h01, 8'h0F, 1, 1);   // R2: low nibble of 0x10 is zero
      run_vec(7, 8'h42, 8'h42, 0, 1);   // R7/R6: compare equal
      run_vec(0, 8'h0F, 8'h01, 0, 1);   // R1: half-carry boundary
      run_vec(2, 8'h10, 8'h01, 0, 1);   // R3: half-borrow
      run_vec(4, 8'hF0, 8'h0F, 1, 0);   // R5/R8: AND zero, carry held
      // exhaustive sweep
      for (int op = 0; op < 8; op++)
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
               for (int cin = 0; cin < 2; cin++)
                  run_vec(op, a, b, cin, ((a >> 1) ^ (b >> 2)) & 1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      wait (cycles >= 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule